// File: doc/BRIEF.md
# Memory Wait-State and CPU Clock Controller

This block sits between the oscillator and the core of a small processor. It keeps an option register that sets the CPU clock rate and the number of wait states for data and instruction memory accesses. It also keeps a one-bit auxiliary register that can switch off the clock output driver. From these settings it produces a CPU clock enable, a memory ready signal, and an output enable for the clock-out pin.

The core pulses `acc_stb` for one CPU clock cycle when an access starts. `acc_instr` marks that access as an instruction fetch. The block then holds `mem_ready` low for the number of CPU clock cycles programmed for that kind of access. Half-rate operation is a clock enable that toggles on every oscillator cycle, so every register in the design stays on the single oscillator clock.

Top module: `memwait_clkctl`

## Requirements
- R1: After reset, the clock select bit is 1 (half rate), the instruction wait count is 3, the data wait count is 7 and clock-out disable is 0. In the first cycle after reset, `cpu_clk_en` is 0, `mem_ready` is 1 and `clk_out_oe` is 1.
- R2: Option register (`cfg_addr`=0) bit 7 selects the clock. With 0, `cpu_clk_en` is 1 on every oscillator cycle. With 1, it alternates between 0 and 1 on successive oscillator cycles.
- R3: A strobe taken with `acc_instr`=0 at an edge where `cpu_clk_en` is 1 starts a data access. `mem_ready` then goes low after that edge and stays low for the number of CPU clock cycles in option bits 2:0.
- R4: A strobe taken with `acc_instr`=1 starts an instruction access. It stalls for the number of CPU clock cycles in option bits 4:3.
- R5: When the selected wait count is 0, `mem_ready` stays high through the access.
- R6: Wait cycles are counted only at edges where `cpu_clk_en` is 1. At half rate, N wait states therefore hold ready low for 2N oscillator cycles, and `mem_ready` never changes after an edge where `cpu_clk_en` was 0.
- R7: The wait count is captured when the access starts. A write to the option register during a stall does not change that stall, and it applies to the next access.
- R8: A strobe is ignored while `mem_ready` is low, and also at an edge where `cpu_clk_en` is 0.
- R9: Auxiliary register (`cfg_addr`=1) bit 0 is clock-out disable. When it is 1, `clk_out_oe` is 0. Writes to that address leave the option register unchanged, and `clk_out_oe` changes only after such a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = option register, 1 = auxiliary register |
| cfg_wdata | input | 8 | Register write data |
| acc_stb | input | 1 | Memory access start strobe |
| acc_instr | input | 1 | 1 = instruction access, 0 = data access |
| cpu_clk_en | output | 1 | CPU clock enable (full or half rate) |
| mem_ready | output | 1 | Low while the current access is being stalled |
| clk_out_oe | output | 1 | Clock-out pin driver enable |

## Verification
The bench measures stall lengths at both clock rates:
- A counter that ignores the clock enable would cut half-rate stalls in half.
- Loading the wrong field would mix up data and instruction counts.

It rewrites the option register in the middle of a stall. A design that read the field live instead of capturing it at the start would stretch or shorten the stall. It also issues strobes during a stall and on disabled edges, where a design that restarts the counter would lengthen the stall or start a stray one. Finally, it checks that wait count zero never drops ready and that writes to the auxiliary address leave the timing fields intact.

// File: rtl/memwait_pkg.sv
// Package: shared widths, field positions and reset values for the
// memory wait-state / clock controller.
package memwait_pkg;

    localparam int CFG_W      = 8;
    localparam int DWS_W      = 3;
    localparam int IWS_W      = 2;
    localparam int CNT_W      = (DWS_W > IWS_W) ? DWS_W : IWS_W;

    // Option register field positions (bit-exact layout the core relies on)
    localparam int CCS_BIT    = 7;
    localparam int IWS_LSB    = 3;
    localparam int DWS_LSB    = 0;
    // Auxiliary register field position
    localparam int COD_BIT    = 0;

    // Option register contents
    typedef struct packed {
        logic             half_rate;
        logic [IWS_W-1:0] iws;
        logic [DWS_W-1:0] dws;
    } opt_t;

    localparam opt_t OPT_RST = '{half_rate: 1'b1, iws: '1, dws: '1};

endpackage

// File: rtl/wsc_optreg.sv
// Module: wsc_optreg
// Holds the option register (clock select, instruction and data wait
// counts) and the auxiliary clock-out disable bit.
// Assumes: writes occur on the oscillator clock; unused data bits are dropped.
module wsc_optreg
    import memwait_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [CFG_W-1:0] wdata,
    output opt_t             opt,
    output logic             cod
);

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^{wdata[6:5], wdata[CFG_W-1:1]};

    // Update the option register on address 0 writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opt <= OPT_RST;
        end else if (wr_en && !addr) begin
            opt.half_rate <= wdata[CCS_BIT];
            opt.iws       <= wdata[IWS_LSB +: IWS_W];
            opt.dws       <= wdata[DWS_LSB +: DWS_W];
        end
    end

    // Update the clock-out disable bit on address 1 writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cod <= 1'b0;
        end else if (wr_en && addr) begin
            cod <= wdata[COD_BIT];
        end
    end

endmodule

// File: rtl/wsc_clkdiv.sv
// Module: wsc_clkdiv
// Produces the CPU clock enable: constant high at full rate, or a toggling
// enable at half rate. No derived clock is generated.
// Assumes: the enable starts low in the first cycle after reset.
module wsc_clkdiv (
    input  logic clk,
    input  logic rst_n,
    input  logic half_rate,
    output logic ce
);

    logic tgl_q;

    // Toggle flip-flop; parked high while running at full rate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
        end else begin
            tgl_q <= half_rate ? ~tgl_q : 1'b1;
        end
    end

    // Select the enable according to the rate
    always_comb begin
        ce = half_rate ? tgl_q : 1'b1;
    end

endmodule

// File: rtl/wsc_waitctr.sv
// Module: wsc_waitctr
// Counts wait states for one access at a time. It loads the count for the
// access type when a strobe is seen on an enabled edge while idle, then
// counts down on enabled edges only.
// Assumes: strobes during a stall are not meaningful and are dropped.
module wsc_waitctr
    import memwait_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             stb,
    input  logic             is_instr,
    input  logic [IWS_W-1:0] iws,
    input  logic [DWS_W-1:0] dws,
    output logic             ready
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    // Pick the wait count for the requested access type
    always_comb begin
        load_val = is_instr ? CNT_W'(iws) : CNT_W'(dws);
    end

    // Remaining wait cycles for the access in progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ce) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (stb) begin
                cnt_q <= load_val;
            end
        end
    end

    // Ready whenever no wait cycles remain
    always_comb begin
        ready = (cnt_q == '0);
    end

endmodule

// File: rtl/memwait_clkctl.sv
// Module: memwait_clkctl (top)
// Memory wait-state and CPU clock controller: registers, clock-enable
// divider and wait counter, all on the oscillator clock.
// Assumes: synchronous active-low reset; access strobes last one CPU cycle.
module memwait_clkctl
    import memwait_pkg::*;
(
    input  logic             clk_osc,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic             cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             acc_stb,
    input  logic             acc_instr,
    output logic             cpu_clk_en,
    output logic             mem_ready,
    output logic             clk_out_oe
);

    opt_t             opt;
    logic             opt_cod;
    logic             opt_ccs;
    logic [IWS_W-1:0] opt_iws;
    logic [DWS_W-1:0] opt_dws;

    wsc_optreg u_reg (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .opt   (opt),
        .cod   (opt_cod)
    );

    // Break the option struct into named fields
    always_comb begin
        opt_ccs = opt.half_rate;
        opt_iws = opt.iws;
        opt_dws = opt.dws;
    end

    wsc_clkdiv u_div (
        .clk       (clk_osc),
        .rst_n     (rst_n),
        .half_rate (opt_ccs),
        .ce        (cpu_clk_en)
    );

    wsc_waitctr u_wait (
        .clk      (clk_osc),
        .rst_n    (rst_n),
        .ce       (cpu_clk_en),
        .stb      (acc_stb),
        .is_instr (acc_instr),
        .iws      (opt_iws),
        .dws      (opt_dws),
        .ready    (mem_ready)
    );

    // Drive the clock-out pin unless disabled
    always_comb begin
        clk_out_oe = ~opt_cod;
    end

endmodule

// File: rtl/memwait_clkctl_chk.sv
// Module: memwait_clkctl_chk
// Temporal checks on the controller, attached to the top by bind.
module memwait_clkctl_chk
    import memwait_pkg::*;
(
    input logic             clk_osc,
    input logic             rst_n,
    input logic             cfg_wr_en,
    input logic             cfg_addr,
    input logic             acc_stb,
    input logic             acc_instr,
    input logic             cpu_clk_en,
    input logic             mem_ready,
    input logic             clk_out_oe,
    input logic             ccs,
    input logic [IWS_W-1:0] iws,
    input logic [DWS_W-1:0] dws
);

    // R2
    full_rate_en_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !ccs |-> cpu_clk_en);

    // R2
    half_rate_alt_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (ccs && $past(ccs) && $past(rst_n)) |-> (cpu_clk_en != $past(cpu_clk_en)));

    // R3
    stall_needs_start_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
        ($past(rst_n) && $fell(mem_ready)) |-> $past(acc_stb && cpu_clk_en));

    // R5
    zero_wait_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (acc_stb && cpu_clk_en && mem_ready &&
         ((acc_instr && iws == '0) || (!acc_instr && dws == '0))) |=> mem_ready);

    // R6
    hold_on_disabled_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
        ($past(rst_n) && !$past(cpu_clk_en)) |-> $stable(mem_ready));

    // R9
    oe_change_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
        ($past(rst_n) && !$stable(clk_out_oe)) |-> $past(cfg_wr_en && cfg_addr));

endmodule

bind memwait_clkctl memwait_clkctl_chk u_chk (
    .clk_osc    (clk_osc),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_addr   (cfg_addr),
    .acc_stb    (acc_stb),
    .acc_instr  (acc_instr),
    .cpu_clk_en (cpu_clk_en),
    .mem_ready  (mem_ready),
    .clk_out_oe (clk_out_oe),
    .ccs        (opt_ccs),
    .iws        (opt_iws),
    .dws        (opt_dws)
);

// File: tb/memwait_clkctl_tb_top.sv
// Bench for memwait_clkctl: directed corner cases plus seeded random
// stimulus, checked against a cycle model written from the requirements.
module memwait_clkctl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk_osc = 1'b0;
    logic       rst_n;
    logic       cfg_wr_en;
    logic       cfg_addr;
    logic [7:0] cfg_wdata;
    logic       acc_stb;
    logic       acc_instr;
    logic       cpu_clk_en;
    logic       mem_ready;
    logic       clk_out_oe;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    // Expected state, kept by the bench
    logic       m_ccs;
    logic [1:0] m_iws;
    logic [2:0] m_dws;
    logic       m_cod;
    logic       m_tgl;
    int         m_cnt;

    always #(CLK_PERIOD/2) clk_osc = ~clk_osc;

    memwait_clkctl dut_i (
        .clk_osc    (clk_osc),
        .rst_n      (rst_n),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .acc_stb    (acc_stb),
        .acc_instr  (acc_instr),
        .cpu_clk_en (cpu_clk_en),
        .mem_ready  (mem_ready),
        .clk_out_oe (clk_out_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic exp_en();
        return m_ccs ? m_tgl : 1'b1;
    endfunction

    // One oscillator cycle: drive, advance the model at the edge, compare
    task automatic cyc(input logic stb, input logic instr, input logic wr,
                       input logic addr, input logic [7:0] d, input string tag);
        logic en_b;
        acc_stb = stb; acc_instr = instr;
        cfg_wr_en = wr; cfg_addr = addr; cfg_wdata = d;
        @(posedge clk_osc);
        en_b = exp_en();
        if (en_b) begin
            if (m_cnt != 0) m_cnt--;
            else if (stb) m_cnt = instr ? int'(m_iws) : int'(m_dws);
        end
        m_tgl = m_ccs ? ~m_tgl : 1'b1;
        if (wr) begin
            if (!addr) begin
                m_ccs = d[7]; m_iws = d[4:3]; m_dws = d[2:0];
            end else begin
                m_cod = d[0];
            end
        end
        @(negedge clk_osc);
        acc_stb = 1'b0; cfg_wr_en = 1'b0;
        chk(cpu_clk_en == exp_en(), {tag, " R2 cpu_clk_en"}, cpu_clk_en, exp_en());
        chk(mem_ready == (m_cnt == 0), {tag, " R3 mem_ready"}, mem_ready, (m_cnt == 0));
        chk(clk_out_oe == !m_cod, {tag, " R9 clk_out_oe"}, clk_out_oe, !m_cod);
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, tag);
    endtask

    task automatic wr_reg(input logic addr, input logic [7:0] d, input string tag);
        cyc(1'b0, 1'b0, 1'b1, addr, d, tag);
    endtask

    task automatic align_en(input logic want, input string tag);
        while (exp_en() != want) idle(tag);
    endtask

    // Start an access on an enabled edge; return the cycles ready was low
    task automatic measure(input logic instr, input string tag, output int n);
        align_en(1'b1, tag);
        cyc(1'b1, instr, 1'b0, 1'b0, 8'h00, tag);
        n = 0;
        while (!mem_ready && n < 100) begin
            n++;
            idle(tag);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk_osc) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_addr = 1'b0; cfg_wdata = 8'h00;
        acc_stb = 1'b0; acc_instr = 1'b0;
        m_ccs = 1'b1; m_iws = 2'd3; m_dws = 3'd7; m_cod = 1'b0; m_tgl = 1'b0; m_cnt = 0;
        repeat (4) @(posedge clk_osc);
        @(negedge clk_osc);
        rst_n = 1'b1;

        // R1 reset state
        chk(cpu_clk_en == 1'b0, "R1 cpu_clk_en after reset", cpu_clk_en, 0);
        chk(mem_ready == 1'b1, "R1 mem_ready after reset", mem_ready, 1);
        chk(clk_out_oe == 1'b1, "R1 clk_out_oe after reset", clk_out_oe, 1);

        // R1 R3 R6: default data wait 7 at half rate -> 14 oscillator cycles
        measure(1'b0, "R6", n);
        chk(n == 14, "R1 R3 R6 default data stall", n, 14);
        // R1 R4 R6: default instruction wait 3 at half rate -> 6
        measure(1'b1, "R4", n);
        chk(n == 6, "R1 R4 R6 default instr stall", n, 6);

        // R2: full rate, iws 0, dws 5
        wr_reg(1'b0, 8'h05, "R2");
        repeat (3) idle("R2");
        measure(1'b0, "R3", n);
        chk(n == 5, "R3 full-rate data stall", n, 5);
        // R5: zero instruction wait keeps ready high
        measure(1'b1, "R5", n);
        chk(n == 0, "R5 zero-wait instr", n, 0);

        // R7: rewrite data wait during a stall
        wr_reg(1'b0, 8'h06, "R7");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R7");
        n = 0;
        while (!mem_ready && n < 100) begin
            n++;
            if (n == 1) wr_reg(1'b0, 8'h01, "R7");
            else idle("R7");
        end
        chk(n == 6, "R7 stall keeps captured count", n, 6);
        measure(1'b0, "R7", n);
        chk(n == 1, "R7 new count on next access", n, 1);

        // R8: strobes during a stall are dropped
        wr_reg(1'b0, 8'h03, "R8");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R8");
        n = 0;
        while (!mem_ready && n < 100) begin
            n++;
            cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R8");
        end
        chk(n == 3, "R8 strobe in stall ignored", n, 3);
        // R8: strobe on a disabled edge at half rate is dropped
        wr_reg(1'b0, 8'h83, "R8");
        idle("R8");
        align_en(1'b0, "R8");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R8");
        chk(mem_ready == 1'b1, "R8 strobe on disabled edge", mem_ready, 1);

        // R9: clock-out disable, option fields untouched
        wr_reg(1'b1, 8'hFF, "R9");
        chk(clk_out_oe == 1'b0, "R9 clock-out disabled", clk_out_oe, 0);
        measure(1'b0, "R9", n);
        chk(n == 6, "R9 aux write keeps data wait", n, 6);
        wr_reg(1'b1, 8'h00, "R9");
        chk(clk_out_oe == 1'b1, "R9 clock-out enabled", clk_out_oe, 1);

        // Random mix against the model (R2 R3 R4 R6 R7 R8 R9)
        for (int i = 0; i < 6000; i++) begin
            logic wr;
            wr = ($urandom_range(0, 19) == 0);
            cyc(($urandom_range(0, 2) == 0), $urandom_range(0, 1), wr,
                $urandom_range(0, 1), 8'($urandom()), "random");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule